// File: doc/BRIEF.md
# Steerable Watchdog Timer

This block watches for a stalled processor. Software programs one byte holding a timeout multiplier, a resolution select and a steering bit. The block counts strobes from the chosen resolution tick source. When the programmed number of those strobes passes without a restart, the watchdog expires. A restart comes from either edge on an external kick pin or from any write to the register.

On expiry the block always sets a sticky flag. A read strobe on the flags register clears that flag. The steering bit chooses the response to an expiry:

- **Interrupt steering.** An active-low interrupt is latched and counting stops. The interrupt is held until software writes 00h, and that write also disables the watchdog.
- **Reset steering.** The block sends out an active-low reset pulse of fixed length, timed in millisecond strobes. It clears its own register and emits a one-cycle request to clear the frequency-test bit that lives elsewhere.

A power-down indication disables the watchdog and clears its register. The tick sources (1/16 s, 1/4 s, 1 s, 4 s strobes and a 1 ms strobe) are made outside this block.

Top module: `steer_wdog`

## Requirements
- R1: The register byte is {steer[7], mult[6:2], res[1:0]}. The watchdog expires on the mult-th strobe of tick_i[res] after the last restart (res 00 = 1/16 s, 01 = 1/4 s, 10 = 1 s, 11 = 4 s). The flag rises at the clock edge that samples that strobe.
- R2: Strobes on tick_i bits other than the one res selects do not advance the count.
- R3: A register value with mult = 0 never expires, whatever the ticks do.
- R4: A rising or a falling edge on kick_i restarts the count. The edge takes effect within KICK_SYNC+1 clocks.
- R5: Any accepted write to the register restarts the count, even a write of the same value.
- R6: flag_o goes to 1 on expiry and stays there until a flag_rd_i strobe clears it. If an expiry and a read happen in the same cycle, the flag is set.
- R7: With steer = 0, an expiry drives irq_no low and halts counting. irq_no stays low through flag reads and nonzero writes. Only a write of 00h releases it.
- R8: With steer = 1, an expiry drives rst_no low for exactly PULSE_MS strobes of ms_tick_i (default 100, i.e. 100 ms).
- R9: With steer = 1, an expiry clears the register to 00h and pulses ft_clr_o for one clock.
- R10: While pwr_down_i is high, the register reads 00h, writes are ignored, no expiry occurs, irq_no is released and any reset pulse is cut short.
- R11: After reset, cfg_o = 00h, flag_o = 0, irq_no = 1, rst_no = 1 and ft_clr_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 4 | Resolution strobes, index = res code |
| ms_tick_i | input | 1 | 1 ms strobe timing the reset pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| kick_i | input | 1 | Asynchronous kick pin, both edges restart |
| flag_rd_i | input | 1 | Flags-register read strobe |
| pwr_down_i | input | 1 | Power-down indication |
| cfg_o | output | 8 | Register readback |
| flag_o | output | 1 | Sticky watchdog flag |
| irq_no | output | 1 | Interrupt request, active low |
| rst_no | output | 1 | Reset pulse, active low |
| ft_clr_o | output | 1 | One-cycle request to clear the frequency-test bit |

## Verification
The hardest situations to reach are coincidences:

- an expiry in the same cycle as a flag read;
- a power-down that arrives in the middle of a reset pulse;
- an interrupt latch that must survive nonzero rewrites while ticks keep arriving.

Directed sequences place a flag read on the cycle of the final strobe. They raise power-down a few clocks into a running pulse. They rewrite the register and keep ticking while the interrupt is held.

Random trials draw the multiplier, resolution and steering. They mix in strobes from the non-selected resolutions, so only the selected source can advance the count. The expected expiry strobe and the expected pulse length are computed in the bench from the register value.

// File: rtl/steer_wdog_pkg.sv
package steer_wdog_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned MULT_W  = 5;
  localparam int unsigned RES_W   = 2;
  localparam int unsigned NUM_RES = 1 << RES_W;

  typedef struct packed {
    logic              steer;
    logic [MULT_W-1:0] mult;
    logic [RES_W-1:0]  res;
  } wdog_cfg_t;
endpackage

// File: rtl/steer_wdog_kick_sync.sv
module steer_wdog_kick_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic edge_o
);
  // STAGES synchroniser flops plus one history flop
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], kick_i};
  end

  assign edge_o = sh_q[STAGES] ^ sh_q[STAGES-1];

  assert_edge_follows_pin_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> (sh_q[STAGES] != $past(sh_q[STAGES])));
endmodule

// File: rtl/steer_wdog_count.sv
module steer_wdog_count #(
  parameter int unsigned MULT_W  = 5,
  parameter int unsigned NUM_RES = 4,
  localparam int unsigned RES_W  = $clog2(NUM_RES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_RES-1:0] tick_i,
  input  logic [RES_W-1:0]   res_i,
  input  logic [MULT_W-1:0]  mult_i,
  input  logic               hold_i,
  input  logic               restart_i,
  output logic               expire_o
);
  localparam logic [MULT_W-1:0] ONE = MULT_W'(1);

  logic [NUM_RES-1:0] hit;
  logic [MULT_W-1:0]  cnt_q;
  logic               sel_tick, armed, last;

  for (genvar g = 0; g < NUM_RES; g++) begin : g_sel
    assign hit[g] = tick_i[g] && (res_i == RES_W'(g));
  end

  assign sel_tick = |hit;
  assign armed    = (mult_i != '0) && !hold_i;
  assign last     = (cnt_q == mult_i - ONE);
  assign expire_o = armed && sel_tick && last && !restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (restart_i)         cnt_q <= '0;
    else if (expire_o)          cnt_q <= '0;
    else if (armed && sel_tick) cnt_q <= cnt_q + ONE;
  end

  assert_cnt_in_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mult_i != '0) |-> (cnt_q < mult_i));
  assert_hold_freezes_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !restart_i) |=> $stable(cnt_q));
endmodule

// File: rtl/steer_wdog_pulse.sv
module steer_wdog_pulse #(
  parameter int unsigned PULSE_MS = 100,
  localparam int unsigned CNT_W   = (PULSE_MS > 2) ? $clog2(PULSE_MS) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ms_tick_i,
  input  logic start_i,
  input  logic abort_i,
  output logic active_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_MS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (abort_i) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (active_q && ms_tick_i) begin
      if (cnt_q == LAST) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign active_o = active_q;

  assert_pulse_bounded_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (cnt_q <= LAST));
  assert_pulse_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_q) |-> $past(start_i));
endmodule

// File: rtl/steer_wdog.sv
module steer_wdog
  import steer_wdog_pkg::*;
#(
  parameter int unsigned PULSE_MS  = 100,
  parameter int unsigned KICK_SYNC = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_RES-1:0] tick_i,
  input  logic               ms_tick_i,
  input  logic               wr_en_i,
  input  logic [REG_W-1:0]   wr_data_i,
  input  logic               kick_i,
  input  logic               flag_rd_i,
  input  logic               pwr_down_i,
  output logic [REG_W-1:0]   cfg_o,
  output logic               flag_o,
  output logic               irq_no,
  output logic               rst_no,
  output logic               ft_clr_o
);
  wdog_cfg_t cfg_q;
  logic flag_q, irq_q, ft_clr_q;
  logic wr_ok, kick_edge, restart, expire, steer_exp, pulse_active;

  assign wr_ok     = wr_en_i && !pwr_down_i;
  assign restart   = wr_ok || kick_edge || pwr_down_i;
  assign steer_exp = expire && cfg_q.steer;

  steer_wdog_kick_sync #(.STAGES(KICK_SYNC)) u_kick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .kick_i (kick_i),
    .edge_o (kick_edge)
  );

  steer_wdog_count #(.MULT_W(MULT_W), .NUM_RES(NUM_RES)) u_count (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .res_i     (cfg_q.res),
    .mult_i    (cfg_q.mult),
    .hold_i    (irq_q),
    .restart_i (restart),
    .expire_o  (expire)
  );

  steer_wdog_pulse #(.PULSE_MS(PULSE_MS)) u_pulse (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ms_tick_i (ms_tick_i),
    .start_i   (steer_exp),
    .abort_i   (pwr_down_i),
    .active_o  (pulse_active)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      flag_q   <= 1'b0;
      irq_q    <= 1'b0;
      ft_clr_q <= 1'b0;
    end else begin
      ft_clr_q <= steer_exp;

      if (pwr_down_i)     cfg_q <= '0;
      else if (wr_ok)     cfg_q <= wdog_cfg_t'(wr_data_i);
      else if (steer_exp) cfg_q <= '0;

      // set wins over a coincident read
      if (expire)         flag_q <= 1'b1;
      else if (flag_rd_i) flag_q <= 1'b0;

      if (pwr_down_i)                         irq_q <= 1'b0;
      else if (expire && !cfg_q.steer)        irq_q <= 1'b1;
      else if (wr_ok && (wr_data_i == '0))    irq_q <= 1'b0;
    end
  end

  assign cfg_o    = cfg_q;
  assign flag_o   = flag_q;
  assign irq_no   = !irq_q;
  assign rst_no   = !pulse_active;
  assign ft_clr_o = ft_clr_q;

  assert_pd_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_down_i |=> ((cfg_o == '0) && irq_no && rst_no));
  assert_irq_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_no) |-> $past(pwr_down_i || (wr_en_i && (wr_data_i == '0))));
  assert_steer_self_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    steer_exp |=> ((cfg_o == '0) && ft_clr_o && !rst_no && flag_o));
  assert_flag_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_rd_i && !expire) |=> !flag_o);
  assert_flag_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> flag_o);
endmodule

// File: tb/steer_wdog_tb_top.sv
module steer_wdog_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PULSE_MS   = 100;
  localparam int MS_DIV     = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] tick_i = '0;
  logic       ms_tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       kick_i = 1'b0;
  logic       flag_rd_i = 1'b0;
  logic       pwr_down_i = 1'b0;
  logic [7:0] cfg_o;
  logic       flag_o, irq_no, rst_no, ft_clr_o;

  int n_chk = 0;
  int n_fail = 0;
  int low_ms = 0;
  int ft_cnt = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  steer_wdog #(.PULSE_MS(PULSE_MS), .KICK_SYNC(2)) dut_i (
    .clk_i, .rst_ni, .tick_i, .ms_tick_i, .wr_en_i, .wr_data_i, .kick_i,
    .flag_rd_i, .pwr_down_i, .cfg_o, .flag_o, .irq_no, .rst_no, .ft_clr_o
  );

  initial begin
    int c = 0;
    forever begin
      @(negedge clk_i);
      c++;
      ms_tick_i = (c % MS_DIV == 0);
    end
  end

  always @(negedge clk_i) begin
    #1;
    if (!rst_no && ms_tick_i) low_ms++;
    if (ft_clr_o) ft_cnt++;
  end

  function automatic logic [7:0] mk_cfg(input bit steer, input int mult, input int res);
    return {steer, mult[4:0], res[1:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    wr_en_i = 1'b1; wr_data_i = v;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic tick(input int idx);
    tick_i[idx] = 1'b1;
    @(negedge clk_i);
    tick_i = '0;
  endtask

  task automatic rdflag();
    flag_rd_i = 1'b1;
    @(negedge clk_i);
    flag_rd_i = 1'b0;
  endtask

  task automatic kick_toggle();
    kick_i = ~kick_i;
    repeat (5) @(negedge clk_i);
  endtask

  task automatic clean();
    wr(8'h00);
    rdflag();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int seed_d;
    seed_d = $urandom(32'h5eed);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R11 reset state
    chk(cfg_o == 8'h00 && flag_o == 0 && irq_no == 1 && rst_no == 1 && ft_clr_o == 0,
        "R11 reset state", {cfg_o, flag_o, irq_no, rst_no, ft_clr_o}, {8'h00, 4'b0110});

    // R2 + R4 rising kick
    wr(8'h0C);
    tick(1); tick(2); tick(3);
    chk(flag_o == 0, "R2 other ticks ignored", flag_o, 0);
    tick(0); tick(0);
    kick_toggle();
    tick(0); tick(0);
    chk(flag_o == 0, "R4 rising kick restart", flag_o, 0);
    tick(0);
    chk(flag_o == 1, "R4 expire after kick", flag_o, 1);
    clean();

    // R4 falling kick
    wr(8'h0C);
    tick(0); tick(0);
    kick_toggle();
    tick(0); tick(0);
    chk(flag_o == 0, "R4 falling kick restart", flag_o, 0);
    tick(0);
    chk(flag_o == 1, "R4 expire after falling kick", flag_o, 1);
    clean();

    // R5 same-value write restarts
    wr(8'h0C);
    tick(0); tick(0);
    wr(8'h0C);
    tick(0); tick(0);
    chk(flag_o == 0, "R5 rewrite restart", flag_o, 0);
    tick(0);
    chk(flag_o == 1, "R5 expire after rewrite", flag_o, 1);
    clean();

    // R3 mult zero
    for (int r = 0; r < 4; r++) begin
      wr(mk_cfg(r[0], 0, r));
      for (int k = 0; k < 10; k++) tick(r);
      chk(flag_o == 0 && irq_no == 1 && rst_no == 1, "R3 mult zero disabled", flag_o, 0);
    end
    clean();

    // R7 irq hold
    wr(8'h04);
    tick(0);
    chk(irq_no == 0 && flag_o == 1, "R7 irq on expire", irq_no, 0);
    rdflag();
    chk(flag_o == 0, "R6 flag read clears", flag_o, 0);
    chk(irq_no == 0, "R7 irq survives flag read", irq_no, 0);
    wr(8'h08);
    chk(irq_no == 0 && cfg_o == 8'h08, "R7 irq survives nonzero write", irq_no, 0);
    tick(0); tick(0); tick(0);
    chk(flag_o == 0, "R7 counting halted", flag_o, 0);
    wr(8'h00);
    chk(irq_no == 1, "R7 00h write releases", irq_no, 1);
    clean();

    // R6 set wins over coincident read
    wr(8'h04);
    tick_i[0] = 1'b1; flag_rd_i = 1'b1;
    @(negedge clk_i);
    tick_i = '0; flag_rd_i = 1'b0;
    chk(flag_o == 1, "R6 set priority", flag_o, 1);
    clean();

    // R10 power down
    wr(8'h0D);
    pwr_down_i = 1'b1;
    @(negedge clk_i);
    chk(cfg_o == 8'h00, "R10 register cleared", cfg_o, 0);
    wr(8'h55);
    chk(cfg_o == 8'h00, "R10 write ignored", cfg_o, 0);
    for (int k = 0; k < 5; k++) tick(1);
    chk(flag_o == 0, "R10 no expiry", flag_o, 0);
    pwr_down_i = 1'b0;
    @(negedge clk_i);
    wr(8'h04);
    tick(0);
    pwr_down_i = 1'b1;
    @(negedge clk_i);
    chk(irq_no == 1, "R10 irq released", irq_no, 1);
    pwr_down_i = 1'b0;
    clean();
    wr(8'h84);
    tick(0);
    repeat (3) @(negedge clk_i);
    chk(rst_no == 0, "R8 pulse running", rst_no, 0);
    pwr_down_i = 1'b1;
    @(negedge clk_i);
    chk(rst_no == 1, "R10 pulse aborted", rst_no, 1);
    pwr_down_i = 1'b0;
    clean();

    // random trials
    for (int t = 0; t < 24; t++) begin
      bit steer;
      int mult, res;
      logic [7:0] v;
      steer = 1'($urandom % 2);
      mult  = 1 + int'($urandom % 6);
      res   = int'($urandom % 4);
      v = mk_cfg(steer, mult, res);
      clean();
      low_ms = 0; ft_cnt = 0;
      wr(v);
      for (int k = 1; k <= mult; k++) begin
        if ($urandom % 2 == 1) begin
          tick((res + 1 + int'($urandom % 3)) % 4);
          chk(flag_o == 0, "R2 non-selected tick", flag_o, 0);
        end
        tick(res);
        if (k < mult)
          chk(flag_o == 0 && irq_no == 1 && rst_no == 1, "R1 early", flag_o, 0);
        else
          chk(flag_o == 1, "R1 expire on mult-th tick", flag_o, 1);
      end
      if (steer) begin
        chk(rst_no == 0, "R8 pulse start", rst_no, 0);
        chk(cfg_o == 8'h00, "R9 register self-cleared", cfg_o, 0);
        for (int w = 0; w < 2000 && rst_no == 0; w++) @(negedge clk_i);
        @(negedge clk_i);
        chk(low_ms == PULSE_MS, "R8 pulse length", low_ms, PULSE_MS);
        chk(ft_cnt == 1, "R9 ft clear pulse", ft_cnt, 1);
      end else begin
        chk(irq_no == 0 && cfg_o == v, "R7 irq steered", {irq_no, cfg_o}, {1'b0, v});
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule